// File: doc/BRIEF.md
# Configurable GPIO Port Bank with Shared Interrupt

This block is a bank of general-purpose I/O ports that sits on a simple register bus of a microcontroller. Each port groups a number of pins. A whole port is set to one of three pad behaviours: an input with a pull-up, an open-drain output, or a push-pull output. Pads are modelled digitally, with an output value, an output enable and a pull-up enable for each pin, plus the raw level coming back from the pad.

Pad levels pass through a two-flop synchroniser. Software reads the synchronised levels through the bus. An edge detector, with the edge direction chosen per port, watches the synchronised levels. Each pin has its own interrupt enable. Any enabled edge on any pin latches a pending event, and all pending events feed one interrupt request line. Pins have no priority among themselves. An acknowledge strobe clears all pending events and leaves every enable bit as it was.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every port is an input with pull-up (pad_oe all 0, pad_pu all 1). All interrupt enables read 0, every port configuration reads 0, and every data register reads 0xFF, so pad_out is all 1.
- R2: Register addressing: bus_addr[3:2] selects the register kind and bus_addr[1:0] selects the port. The kinds are 0 for pin level (read) or data (write), 1 for configuration, 2 for interrupt enable, and 3 for data (read and write). A write changes only the addressed register of the addressed port. Reads of bus_rdata are combinational.
- R3: Configuration bits [1:0] select the mode: 00 or 11 is input with pull-up, 01 is open-drain, 10 is push-pull. In input mode pad_oe is 0, pad_pu is 1 and pad_out follows the data register.
- R4: In open-drain mode pad_out is 0 and pad_pu is 0, and pad_oe is the inverse of the data register, so a 0 pulls the pad low and a 1 releases it. No pin ever has pad_oe and pad_pu both set.
- R5: In push-pull mode pad_oe is 1, pad_pu is 0 and pad_out equals the data register.
- R6: A pin-level read returns pad_in as seen through two flops. A change driven before rising edge k is visible from edge k+1 onward and is not visible after edge k.
- R7: Configuration bit 2 selects the edge for the whole port: 0 for rising, 1 for falling. An edge on an enabled pin is seen at edge k+1 and raises irq after edge k+2. An edge on a disabled pin, or of the other direction, does not raise irq.
- R8: Every enabled pin on every port drives the same irq line, with no priority. Events on one pin, on several pins, or on different ports each raise irq.
- R9: A cycle with irq_ack high clears all pending events, so irq is low in the following cycle. The interrupt enable registers keep their values. An edge detected in the same cycle as the acknowledge stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 4 | {register kind, port} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| pad_in | input | 32 | Pad levels, port p at bits [8p+7:8p] |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pad pull-up enables |
| irq | output | 1 | Shared GPIO interrupt request |

## Verification
Register writes reach the pad outputs one clock edge after the write is sampled. The bench therefore checks pad signals at the falling edge after the write cycle. A pad change driven at a falling edge appears in a pin read after the second rising edge and raises irq after the third. The bench samples one cycle early, where the old value or a low irq is expected, and then on time, where the new value is expected. An acknowledge clears irq at the next edge. The race case lines up the acknowledge with the cycle in which the edge is detected, to show that the new event survives.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPORT = 4,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [WIDTH-1:0]       bus_wdata,
  output logic [WIDTH-1:0]       bus_rdata,
  input  logic                   irq_ack,
  input  logic [NPORT*WIDTH-1:0] pad_in,
  output logic [NPORT*WIDTH-1:0] pad_out,
  output logic [NPORT*WIDTH-1:0] pad_oe,
  output logic [NPORT*WIDTH-1:0] pad_pu,
  output logic                   irq
);
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int AW   = PW + 2;
  localparam int NPIN = NPORT * WIDTH;
  localparam logic [1:0] K_PIN = 2'd0, K_CFG = 2'd1, K_IEN = 2'd2, K_DATA = 2'd3;

  logic [WIDTH-1:0] data_q [NPORT];
  logic [WIDTH-1:0] ien_q  [NPORT];
  logic [2:0]       cfg_q  [NPORT];
  logic [NPIN-1:0]  s1, s2, s3, pend_q, hit, ien_flat;

  wire [1:0]    kind = bus_addr[AW-1:PW];
  wire [PW-1:0] port = bus_addr[PW-1:0];
  wire          wr   = bus_sel & bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) begin
        data_q[p] <= '1;
        ien_q[p]  <= '0;
        cfg_q[p]  <= '0;
      end
    end else if (wr) begin
      for (int p = 0; p < NPORT; p++) begin
        if (port == PW'(p)) begin
          case (kind)
            K_PIN, K_DATA: data_q[p] <= bus_wdata;
            K_CFG:         cfg_q[p]  <= bus_wdata[2:0];
            default:       ien_q[p]  <= bus_wdata;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; pend_q <= '0;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
      s3 <= s2;
      pend_q <= (irq_ack ? '0 : pend_q) | hit;
    end
  end

  assign irq = |pend_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    wire [1:0]       mode = cfg_q[p][1:0];
    wire [WIDTH-1:0] rise = s2[p*WIDTH +: WIDTH] & ~s3[p*WIDTH +: WIDTH];
    wire [WIDTH-1:0] fall = ~s2[p*WIDTH +: WIDTH] & s3[p*WIDTH +: WIDTH];
    assign hit[p*WIDTH +: WIDTH]      = (cfg_q[p][2] ? fall : rise) & ien_q[p];
    assign ien_flat[p*WIDTH +: WIDTH] = ien_q[p];
    assign pad_out[p*WIDTH +: WIDTH]  = (mode == 2'b01) ? '0 : data_q[p];
    assign pad_oe[p*WIDTH +: WIDTH]   = (mode == 2'b10) ? '1 :
                                        (mode == 2'b01) ? ~data_q[p] : '0;
    assign pad_pu[p*WIDTH +: WIDTH]   = (mode == 2'b00 || mode == 2'b11) ? '1 : '0;
  end

  always_comb begin
    case (kind)
      K_PIN:   bus_rdata = s2[port*WIDTH +: WIDTH];
      K_CFG:   bus_rdata = WIDTH'(cfg_q[port]);
      K_IEN:   bus_rdata = ien_q[port];
      default: bus_rdata = data_q[port];
    endcase
  end

  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '1 && pad_out == '1 && ien_flat == '0));

  p_no_drive_with_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pad_oe & pad_pu)));

  p_irq_needs_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|hit));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(|hit)) |=> !irq);

  p_ack_keeps_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wr) |=> $stable(ien_flat));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0, irq_ack = 0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu;
  logic        irq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input logic [1:0] port, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = {kind, port}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] kind, input logic [1:0] port,
                        input logic [7:0] exp);
    bus_sel = 1; bus_we = 0; bus_addr = {kind, port};
    #1;
    chk(tag, {24'd0, bus_rdata}, {24'd0, exp});
    bus_sel = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
    chk("R1 pad_out", pad_out, 32'hFFFF_FFFF);
    for (int p = 0; p < 4; p++) begin
      rd_chk("R1 ien", 2'd2, 2'(p), 8'h00);
      rd_chk("R1 cfg", 2'd1, 2'(p), 8'h00);
      rd_chk("R1 data", 2'd3, 2'(p), 8'hFF);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_modes();
    wr(2'd3, 2'd1, 8'hA5);
    rd_chk("R2 data readback", 2'd3, 2'd1, 8'hA5);
    rd_chk("R2 other port data", 2'd3, 2'd0, 8'hFF);
    chk("R3 input pad_out follows data", pad_out[15:8], 32'hA5);
    wr(2'd1, 2'd1, 8'h01);
    chk("R4 od pad_oe", pad_oe[15:8], 32'h5A);
    chk("R4 od pad_out", pad_out[15:8], 32'h00);
    chk("R4 od pad_pu", pad_pu[15:8], 32'h00);
    chk("R2 other ports untouched", {pad_pu[31:16], pad_pu[7:0]}, 32'hFF_FFFF);
    wr(2'd1, 2'd1, 8'h02);
    chk("R5 pp pad_oe", pad_oe[15:8], 32'hFF);
    chk("R5 pp pad_out", pad_out[15:8], 32'hA5);
    chk("R5 pp pad_pu", pad_pu[15:8], 32'h00);
    wr(2'd1, 2'd1, 8'h03);
    chk("R3 mode 11 pad_oe", pad_oe[15:8], 32'h00);
    chk("R3 mode 11 pad_pu", pad_pu[15:8], 32'hFF);
    wr(2'd0, 2'd1, 8'hFF);
    rd_chk("R2 kind0 write lands in data", 2'd3, 2'd1, 8'hFF);
    wr(2'd1, 2'd1, 8'h00);
    rd_chk("R2 cfg readback", 2'd1, 2'd1, 8'h00);
  endtask

  task automatic t_sync();
    @(negedge clk); pad_in[23:16] = 8'h3C;
    @(negedge clk);
    rd_chk("R6 not yet visible", 2'd0, 2'd2, 8'h00);
    @(negedge clk);
    rd_chk("R6 visible after two flops", 2'd0, 2'd2, 8'h3C);
  endtask

  task automatic t_irq_edge();
    wr(2'd2, 2'd0, 8'h08);
    @(negedge clk); pad_in[3] = 1;
    @(negedge clk); @(negedge clk);
    chk("R7 irq not early", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R7 rising edge irq", {31'd0, irq}, 32'd1);
    ack();
    chk("R9 ack clears irq", {31'd0, irq}, 32'd0);
    rd_chk("R9 enables kept", 2'd2, 2'd0, 8'h08);
    @(negedge clk); pad_in[4] = 1;
    wait_n(4);
    chk("R7 disabled pin no irq", {31'd0, irq}, 32'd0);
    wr(2'd1, 2'd0, 8'h04);
    @(negedge clk); pad_in[3] = 0;
    wait_n(3);
    chk("R7 falling edge irq", {31'd0, irq}, 32'd1);
    ack();
    @(negedge clk); pad_in[3] = 1;
    wait_n(4);
    chk("R7 rising ignored when falling selected", {31'd0, irq}, 32'd0);
    wr(2'd1, 2'd0, 8'h00);
    wr(2'd2, 2'd0, 8'h00);
  endtask

  task automatic t_shared();
    wr(2'd2, 2'd3, 8'h80);
    wr(2'd2, 2'd1, 8'h01);
    @(negedge clk); pad_in[31] = 1; pad_in[8] = 1;
    wait_n(3);
    chk("R8 two ports together", {31'd0, irq}, 32'd1);
    ack();
    @(negedge clk); pad_in[31] = 0; pad_in[8] = 0;
    wait_n(4);
    chk("R8 falls ignored", {31'd0, irq}, 32'd0);
    @(negedge clk); pad_in[31] = 1;
    wait_n(3);
    chk("R8 port3 alone", {31'd0, irq}, 32'd1);
    ack();
    @(negedge clk); pad_in[8] = 1;
    wait_n(3);
    chk("R8 port1 alone", {31'd0, irq}, 32'd1);
    ack();
  endtask

  task automatic t_ack_race();
    @(negedge clk); pad_in[8] = 0;
    wait_n(4);
    chk("R9 idle before race", {31'd0, irq}, 32'd0);
    @(negedge clk); pad_in[8] = 1;
    wait_n(2);
    irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R9 edge with ack stays pending", {31'd0, irq}, 32'd1);
    ack();
    chk("R9 second ack clears", {31'd0, irq}, 32'd0);
    rd_chk("R9 port3 enable kept", 2'd2, 2'd3, 8'h80);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    t_reset();
    t_modes();
    t_sync();
    t_irq_edge();
    t_shared();
    t_ack_race();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule